// File: doc/BRIEF.md
# SPI Command Front-End for a Small UART

This block is the host-facing half of a serial port. A host talks to it over a 16-bit, mode-0 SPI link and each frame begins with a two-bit command. The command either writes the configuration word, reads it back, sends a transmit word (and at the same time collects a received word), or only collects a received word. The block holds the configuration fields and a one-word transmit buffer. It drives the RTS level toward the line side. Received words are queued in a small FIFO until the host fetches them. The UART engine behind it consumes the configuration outputs and the transmit buffer, and pushes received characters into the queue.

Every response starts with two status bits that show whether a received word is waiting and whether the transmit buffer is free. Both bits are frozen when chip select falls, so they describe the state before the frame's own command acts. A frame that chip select ends before its sixteenth clock has no effect at all. A host can therefore raise chip select after two bits and use the result as a cheap status poll.

The SPI pins and the CTS input are sampled by the system clock through a synchronizer, so the SPI clock must be several times slower than the system clock.

Top module: `uspi_front`

## Requirements
- R1: The link runs in SPI mode 0. MOSI is taken on each rising SCLK edge and MISO changes after each falling edge, MSB first, 16 bits per frame. Frame bits 15:14 are the command: 11 writes configuration, 01 reads configuration, 10 writes data, 00 reads data.
- R2: Response bit 15 is 1 when the receive queue held at least one word when chip select fell. Response bit 14 is 1 when the transmit buffer was empty at that moment. A data write therefore still shows bit 14 = 1 in its own response.
- R3: If chip select rises before the 16th rising SCLK edge, the frame changes neither the configuration, nor the transmit buffer, nor RTS, nor the receive queue. A two-bit frame still returns valid status bits.
- R4: A completed configuration write stores frame bits 13:0. Bit 13 selects a single-entry receive queue, bit 12 is soft shutdown, bits 11:8 are the four interrupt enables, bit 7 is infrared mode, bit 6 selects two stop bits, bit 5 enables parity, bit 4 selects 7-bit characters and bits 3:0 are the baud divisor. These fields appear unchanged on the configuration outputs and change at no other time.
- R5: Response bits 13:0 of both configuration commands are the configuration stored when the frame began. A write returns the old value.
- R6: A completed data write with bit 10 = 0, issued while the buffer was empty, loads {bit 8, bits 7:0} into `tx_word_o` and raises `tx_pend_o`. `tx_pend_o` stays high and `tx_word_o` stays stable until `tx_take_i` is pulsed.
- R7: A data write issued while the transmit buffer was full is discarded, and the pending word is kept.
- R8: Every completed data write copies frame bit 9 to `rts_o`. With bit 10 = 1, nothing is loaded for transmit.
- R9: The response bits of both data commands are laid out as follows: bits 13:11 are 0, bit 10 is the framing flag, bit 9 is the synchronized CTS level captured at frame start, bit 8 is the received parity bit and bits 7:0 are the received data, all from the oldest queued word. When the queue was empty, every bit except bit 9 is 0.
- R10: A queued word is removed only by a data read or data write that completes all 16 bits with response bit 15 = 1. Configuration frames never remove one.
- R11: The queue keeps arrival order and holds RX_DEPTH words. A push into a full queue is dropped. With configuration bit 13 set, the queue accepts a push only when it is empty.
- R12: MISO is driven low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | SPI clock from host |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data from host |
| spi_miso_o | output | 1 | SPI data to host |
| cfg_fifo_off_o | output | 1 | Receive queue limited to one entry |
| cfg_shdn_o | output | 1 | Soft shutdown request |
| cfg_irq_en_o | output | 4 | Interrupt enables (TX empty, RX ready, parity, RX activity) |
| cfg_irda_o | output | 1 | Infrared pulse mode |
| cfg_stop2_o | output | 1 | Two stop bits |
| cfg_par_en_o | output | 1 | Parity bit enabled |
| cfg_len7_o | output | 1 | 7-bit characters |
| cfg_baud_o | output | 4 | Baud divisor code |
| tx_word_o | output | 9 | Transmit word {parity, data} |
| tx_pend_o | output | 1 | Transmit word waiting |
| tx_take_i | input | 1 | Engine consumed the transmit word |
| rts_o | output | 1 | RTS level |
| rx_push_i | input | 1 | Engine delivers a received character |
| rx_data_i | input | 8 | Received character |
| rx_par_i | input | 1 | Received parity bit |
| rx_ferr_i | input | 1 | Framing error / shutdown activity flag |
| cts_i | input | 1 | CTS level from line side |

## Verification
The assertions check the hold rules on every cycle. The configuration fields and RTS move only in the cycle a frame completes. A pending transmit word stays put until it is taken. The queue level never drops without a completed frame and never exceeds its depth. The frozen receive-ready bit matches the queue level at frame start, and MISO stays low outside a frame. Only the bench scenarios can show the meaning of frames: the command decode, the one-frame status lag, discarded writes, the no-effect rule for short frames, queue order and overflow, the single-entry mode, and the exact layout of each response.

// File: rtl/uspi_pkg.sv
package uspi_pkg;
   localparam int FRAME_W  = 16;
   localparam int BODY_W   = 14;
   localparam int RXW_W    = 10;   // {ferr, par, data[7:0]}
   localparam int CNT_W    = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {
      CMD_RD_DATA = 2'b00,
      CMD_RD_CFG  = 2'b01,
      CMD_WR_DATA = 2'b10,
      CMD_WR_CFG  = 2'b11
   } cmd_e;

   // configuration field positions
   localparam int CF_FIFO_OFF = 13;
   localparam int CF_SHDN     = 12;
   localparam int CF_IRQ_HI   = 11;
   localparam int CF_IRQ_LO   = 8;
   localparam int CF_IRDA     = 7;
   localparam int CF_STOP2    = 6;
   localparam int CF_PAR_EN   = 5;
   localparam int CF_LEN7     = 4;
   localparam int CF_BAUD_HI  = 3;

   // data frame field positions
   localparam int DF_NOTX     = 10;
   localparam int DF_RTS      = 9;
   localparam int DF_PAR      = 8;
endpackage

// File: rtl/uspi_sync.sv
module uspi_sync #(
   parameter int            WIDTH   = 1,
   parameter int            STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uspi_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= din;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/uspi_rxq.sv
module uspi_rxq #(
   parameter int DEPTH = 4,
   parameter int W     = 10,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          single,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("uspi_rxq: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_reg
      logic         held;
      logic [W-1:0] hold_q;
      logic         unused_single;
      assign unused_single = single;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held   <= 1'b0;
            hold_q <= '0;
         end else if (push && !held) begin
            held   <= 1'b1;
            hold_q <= din;
         end else if (pop) begin
            held   <= 1'b0;
         end
      end
      assign dout  = hold_q;
      assign level = LW'(held);
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] rd_q, wr_q;
      logic [LW-1:0] lvl_q;
      logic          full, push_ok, pop_ok;

      assign full    = single ? (lvl_q != '0) : (lvl_q == LW'(DEPTH));
      assign push_ok = push && !full;
      assign pop_ok  = pop && (lvl_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            lvl_q <= '0;
         end else begin
            if (push_ok)
               wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            if (pop_ok)
               rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            lvl_q <= lvl_q + LW'(push_ok) - LW'(pop_ok);
         end
      end

      always_ff @(posedge clk) begin
         if (push_ok) mem[wr_q] <= din;
      end

      assign dout  = mem[rd_q];
      assign level = lvl_q;
   end
endmodule

// File: rtl/uspi_link.sv
module uspi_link
   import uspi_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               csn_s,
   input  logic               mosi_s,
   input  logic               st_r,
   input  logic               st_t,
   input  logic [BODY_W-1:0]  cfg_now,
   input  logic [BODY_W-1:0]  dat_now,
   output logic               miso,
   output logic               frm_start,
   output logic               frm_done,
   output logic [FRAME_W-1:0] frm_word,
   output logic               snap_r,
   output logic               snap_t
);
   logic               sclk_q, csn_q, active, is_cfg;
   logic [CNT_W-1:0]   rise_n, fall_n;
   logic [FRAME_W-2:0] in_sr;
   logic [BODY_W-1:0]  cfg_snap, dat_snap, body;
   logic [CNT_W-1:0]   pos;
   logic               rise, fall;

   assign frm_start = csn_q && !csn_s;
   assign rise      = active && !csn_s && sclk_s && !sclk_q;
   assign fall      = active && !csn_s && !sclk_s && sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         csn_q    <= 1'b1;
         active   <= 1'b0;
         is_cfg   <= 1'b0;
         rise_n   <= '0;
         fall_n   <= '0;
         in_sr    <= '0;
         cfg_snap <= '0;
         dat_snap <= '0;
         snap_r   <= 1'b0;
         snap_t   <= 1'b0;
         frm_done <= 1'b0;
         frm_word <= '0;
      end else begin
         sclk_q   <= sclk_s;
         csn_q    <= csn_s;
         frm_done <= 1'b0;
         if (frm_start) begin
            active   <= 1'b1;
            is_cfg   <= 1'b0;
            rise_n   <= '0;
            fall_n   <= '0;
            snap_r   <= st_r;
            snap_t   <= st_t;
            cfg_snap <= cfg_now;
            dat_snap <= dat_now;
         end else if (csn_s) begin
            active <= 1'b0;
         end else begin
            if (rise && rise_n < CNT_W'(FRAME_W)) begin
               in_sr  <= {in_sr[FRAME_W-3:0], mosi_s};
               rise_n <= rise_n + 1'b1;
               if (rise_n == CNT_W'(1))
                  is_cfg <= mosi_s;
               if (rise_n == CNT_W'(FRAME_W-1)) begin
                  frm_done <= 1'b1;
                  frm_word <= {in_sr, mosi_s};
               end
            end
            if (fall && fall_n < CNT_W'(FRAME_W-1))
               fall_n <= fall_n + 1'b1;
         end
      end
   end

   assign body = is_cfg ? cfg_snap : dat_snap;
   assign pos  = CNT_W'(FRAME_W-1) - fall_n;

   always_comb begin
      if (!active || csn_s)           miso = 1'b0;
      else if (fall_n == '0)          miso = snap_r;
      else if (fall_n == CNT_W'(1))   miso = snap_t;
      else                            miso = body[pos[$clog2(BODY_W)-1:0]];
   end
endmodule

// File: rtl/uspi_front.sv
module uspi_front
   import uspi_pkg::*;
#(
   parameter int RX_DEPTH    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sclk_i,
   input  logic       spi_cs_n_i,
   input  logic       spi_mosi_i,
   output logic       spi_miso_o,
   output logic       cfg_fifo_off_o,
   output logic       cfg_shdn_o,
   output logic [3:0] cfg_irq_en_o,
   output logic       cfg_irda_o,
   output logic       cfg_stop2_o,
   output logic       cfg_par_en_o,
   output logic       cfg_len7_o,
   output logic [3:0] cfg_baud_o,
   output logic [8:0] tx_word_o,
   output logic       tx_pend_o,
   input  logic       tx_take_i,
   output logic       rts_o,
   input  logic       rx_push_i,
   input  logic [7:0] rx_data_i,
   input  logic       rx_par_i,
   input  logic       rx_ferr_i,
   input  logic       cts_i
);
   localparam int LW = $clog2(RX_DEPTH + 1);

   if (RX_DEPTH < 1 || RX_DEPTH > 64) begin : g_bad_depth
      $error("uspi_front: RX_DEPTH out of range");
   end

   logic [3:0]          pins_s;
   logic                sclk_s, csn_s, mosi_s, cts_s;
   logic                frm_start, frm_done, snap_r, snap_t;
   logic [FRAME_W-1:0]  frm_word;
   logic [BODY_W-1:0]   cfg_q, dat_now;
   logic [RXW_W-1:0]    rx_head;
   logic [LW-1:0]       rx_level;
   logic                rx_pop, rx_any;
   cmd_e                cmd;

   uspi_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_sclk_i, spi_cs_n_i, spi_mosi_i, cts_i}),
      .dout (pins_s)
   );
   assign {sclk_s, csn_s, mosi_s, cts_s} = pins_s;

   assign rx_any  = (rx_level != '0);
   assign dat_now = rx_any ? {3'b000, rx_head[9], cts_s, rx_head[8], rx_head[7:0]}
                           : {4'b0000, cts_s, 9'b0};

   uspi_link u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .csn_s    (csn_s),
      .mosi_s   (mosi_s),
      .st_r     (rx_any),
      .st_t     (!tx_pend_o),
      .cfg_now  (cfg_q),
      .dat_now  (dat_now),
      .miso     (spi_miso_o),
      .frm_start(frm_start),
      .frm_done (frm_done),
      .frm_word (frm_word),
      .snap_r   (snap_r),
      .snap_t   (snap_t)
   );

   assign cmd    = cmd_e'(frm_word[FRAME_W-1:FRAME_W-2]);
   assign rx_pop = frm_done && !frm_word[FRAME_W-2] && snap_r;

   uspi_rxq #(.DEPTH(RX_DEPTH), .W(RXW_W)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .single(cfg_q[CF_FIFO_OFF]),
      .push  (rx_push_i),
      .din   ({rx_ferr_i, rx_par_i, rx_data_i}),
      .pop   (rx_pop),
      .dout  (rx_head),
      .level (rx_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         rts_o     <= 1'b0;
         tx_word_o <= '0;
         tx_pend_o <= 1'b0;
      end else begin
         if (tx_take_i) tx_pend_o <= 1'b0;
         if (frm_done) begin
            case (cmd)
               CMD_WR_CFG: cfg_q <= frm_word[BODY_W-1:0];
               CMD_WR_DATA: begin
                  rts_o <= frm_word[DF_RTS];
                  if (!frm_word[DF_NOTX] && snap_t) begin
                     tx_word_o <= frm_word[DF_PAR:0];
                     tx_pend_o <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign cfg_fifo_off_o = cfg_q[CF_FIFO_OFF];
   assign cfg_shdn_o     = cfg_q[CF_SHDN];
   assign cfg_irq_en_o   = cfg_q[CF_IRQ_HI:CF_IRQ_LO];
   assign cfg_irda_o     = cfg_q[CF_IRDA];
   assign cfg_stop2_o    = cfg_q[CF_STOP2];
   assign cfg_par_en_o   = cfg_q[CF_PAR_EN];
   assign cfg_len7_o     = cfg_q[CF_LEN7];
   assign cfg_baud_o     = cfg_q[CF_BAUD_HI:0];
endmodule

// File: rtl/uspi_front_chk.sv
module uspi_front_chk #(
   parameter int RX_DEPTH = 4,
   localparam int LW = $clog2(RX_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          csn_s,
   input logic          miso,
   input logic          frm_start,
   input logic          frm_done,
   input logic          snap_r,
   input logic [LW-1:0] rx_level,
   input logic          tx_pend,
   input logic          tx_take,
   input logic [8:0]    tx_word,
   input logic          rts,
   input logic [13:0]   cfg
);
   a_r12_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |-> !miso);

   a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pend && !tx_take) |=> (tx_pend && $stable(tx_word)));

   a_r4_cfg_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_done |=> $stable(cfg));

   a_r8_rts_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_done |=> $stable(rts));

   a_r10_no_pop_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_done |=> (rx_level >= $past(rx_level)));

   a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= LW'(RX_DEPTH));

   a_r2_ready_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |=> (snap_r == ($past(rx_level) != '0)));
endmodule

bind uspi_front uspi_front_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .csn_s    (csn_s),
   .miso     (spi_miso_o),
   .frm_start(frm_start),
   .frm_done (frm_done),
   .snap_r   (snap_r),
   .rx_level (rx_level),
   .tx_pend  (tx_pend_o),
   .tx_take  (tx_take_i),
   .tx_word  (tx_word_o),
   .rts      (rts_o),
   .cfg      (cfg_q)
);

// File: tb/uspi_front_tb.sv
module uspi_front_tb;
   localparam int H = 8;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso;
   logic fifo_off, shdn, irda, stop2, par_en, len7;
   logic [3:0] irq_en, baud;
   logic [8:0] tx_word;
   logic tx_pend, rts;
   logic tx_take = 1'b0, rx_push = 1'b0, rx_par = 1'b0, rx_ferr = 1'b0, cts = 1'b1;
   logic [7:0] rx_data = '0;

   int errors = 0, checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   uspi_front #(.RX_DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi), .spi_miso_o(miso),
      .cfg_fifo_off_o(fifo_off), .cfg_shdn_o(shdn), .cfg_irq_en_o(irq_en),
      .cfg_irda_o(irda), .cfg_stop2_o(stop2), .cfg_par_en_o(par_en),
      .cfg_len7_o(len7), .cfg_baud_o(baud),
      .tx_word_o(tx_word), .tx_pend_o(tx_pend), .tx_take_i(tx_take), .rts_o(rts),
      .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_par_i(rx_par),
      .rx_ferr_i(rx_ferr), .cts_i(cts)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] r);
      r = '0;
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         mosi = w[15-i];
         repeat (H) @(negedge clk);
         r[15-i] = miso;
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (3*H) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] d, input logic p, input logic f);
      @(negedge clk);
      rx_push = 1'b1; rx_data = d; rx_par = p; rx_ferr = f;
      @(negedge clk);
      rx_push = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [13:0] cfg_out();
      return {fifo_off, shdn, irq_en, irda, stop2, par_en, len7, baud};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] r;
      logic [13:0] prev, v;
      logic [7:0]  d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // reset state
      check("R12 miso idle", 32'(miso), 0);
      check("R4 cfg reset", 32'(cfg_out()), 0);
      check("R6 tx reset", 32'({tx_pend, rts}), 0);

      // empty read: T=1, CTS=1 in bit 9
      xfer(16'h0000, 16, r);
      check("R9 empty data read", 32'(r), 32'h4200);

      // configuration sweep
      prev = '0;
      for (int k = 0; k < 40; k++) begin
         v = 14'((k * 32'h2B9) ^ (k << 7) ^ 32'h1555);
         xfer({2'b11, v}, 16, r);
         check("R5 cfg write returns old", 32'(r), 32'({2'b01, prev}));
         check("R4 cfg fields", 32'(cfg_out()), 32'(v));
         xfer(16'h4000, 16, r);
         check("R5 cfg read", 32'(r), 32'({2'b01, v}));
         check("R1 cfg read no change", 32'(cfg_out()), 32'(v));
         prev = v;
      end
      xfer(16'hC000, 16, r);
      check("R4 cfg clear", 32'(cfg_out()), 0);

      // aborted config write and 2-bit poll
      xfer(16'hFFFF, 8, r);
      check("R3 aborted cfg write", 32'(cfg_out()), 0);
      xfer(16'h0000, 2, r);
      check("R3 two-bit poll", 32'(r[15:14]), 32'b01);

      // data write
      xfer(16'h83A5, 16, r);
      check("R2 T before write", 32'(r), 32'h4200);
      check("R6 tx loaded", 32'({tx_pend, tx_word}), 32'h3A5);
      check("R8 rts set", 32'(rts), 1);

      // write while full
      xfer(16'h805A, 16, r);
      check("R2 T full", 32'(r), 32'h0200);
      check("R7 write discarded", 32'({tx_pend, tx_word}), 32'h3A5);
      check("R8 rts cleared", 32'(rts), 0);

      // take, then handshake-only
      @(negedge clk); tx_take = 1'b1; @(negedge clk); tx_take = 1'b0;
      repeat (2) @(negedge clk);
      check("R6 take clears", 32'(tx_pend), 0);
      xfer(16'h8600, 16, r);
      check("R8 no-tx response", 32'(r), 32'h4200);
      check("R8 no-tx keeps empty", 32'(tx_pend), 0);
      check("R8 rts via handshake", 32'(rts), 1);

      // aborted data write
      xfer(16'h80FF, 8, r);
      check("R3 aborted data write", 32'({tx_pend, rts}), 32'b01);

      // receive queue, depth+1 pushes, CTS low
      cts = 1'b0;
      for (int i = 0; i <= DEPTH; i++)
         push(8'(8'h30 + i*7), i[0], (i == 2));
      xfer(16'h4000, 16, r);
      check("R10 cfg read keeps queue", 32'(r[15:14]), 32'b11);
      xfer(16'h0000, 2, r);
      check("R3 short poll no pop", 32'(r[15:14]), 32'b11);
      for (int i = 0; i < DEPTH; i++) begin
         d = 8'(8'h30 + i*7);
         xfer(16'h0000, 16, r);
         check("R11 queue order", 32'(r),
               32'({2'b11, 3'b000, (i == 2), 1'b0, i[0], d}));
      end
      xfer(16'h0000, 16, r);
      check("R11 overflow dropped", 32'(r), 32'h4000);
      check("R9 empty fields zero", 32'(r[13:0]), 0);

      // single-entry mode
      xfer(16'hE000, 16, r);
      check("R4 fifo off field", 32'(fifo_off), 1);
      push(8'h11, 1'b0, 1'b0);
      push(8'h22, 1'b1, 1'b0);
      xfer(16'h0000, 16, r);
      check("R11 single entry", 32'(r), 32'hC011);
      xfer(16'h0000, 16, r);
      check("R11 second dropped", 32'(r), 32'h4000);

      // data write pops too
      push(8'h5C, 1'b1, 1'b1);
      xfer(16'h8400, 16, r);
      check("R10 write pops data", 32'(r), 32'hC55C);
      xfer(16'h0000, 16, r);
      check("R10 queue empty after", 32'(r), 32'h4000);
      check("R12 miso idle end", 32'(miso), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule